// File: doc/BRIEF.md
# Frame Clock Lock Monitor

This block watches a frame clock that arrives from outside the chip and checks that it keeps a fixed period relative to the master clock that runs the block. After a two-stage synchronizer it finds each rising edge of the frame clock, counts master-clock cycles from one rising edge to the next, and compares that length with the ratio the rate-select pin implies: 256 cycles in normal rate, 128 in double rate. Only the length of a frame is judged. The edge position relative to the master clock and the duty cycle of the frame clock have no effect.

While the frame length is wrong, the block holds the downstream datapath in reset. This covers a changed clock frequency, a toggled rate pin, and a frame clock that has stopped. Once four frames in a row measure correctly, the block releases that reset and raises a lock flag. The reset is released again with no action from outside, so the external reset is needed only at power-up. The pins are plain level signals and there is no data stream.

Top module: `frame_phase_monitor`

## Requirements
- R1: A frame is the number of `mclk` cycles between two consecutive rising edges of `lrck`. Its expected value is 256 when `rate_hi` is 0 and 128 when `rate_hi` is 1.
- R2: A locked monitor unlocks when it judges a frame whose length differs from the expected value by any amount (for example 255 or 257). Unlocking means `locked` = 0 and `dp_rst_n` = 0.
- R3: Any change on `rate_hi` unlocks the monitor. The next `lrck` rising edge after the change serves only as a new reference and is not judged.
- R4: If no `lrck` rising edge is seen for 512 `mclk` cycles, the monitor unlocks. It stays unlocked until edges return and four good frames have been measured.
- R5: `locked` rises only after four consecutive correctly measured frames that follow a reference edge. Any bad frame, rate change or timeout restarts that count.
- R6: The high time of `lrck` and its phase relative to `mclk` have no effect on locking. Only the spacing of rising edges matters.
- R7: While `ext_rst_n` is 0, `locked` and `dp_rst_n` are 0 at once (asynchronous). After release, the monitor needs a reference edge followed by four good frames before it locks.
- R8: `dp_rst_n` is 1 exactly when `locked` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; the block runs on it |
| ext_rst_n | input | 1 | Power-up reset, active low, asserted asynchronously |
| lrck | input | 1 | Frame clock, asynchronous to the block and synchronized inside it |
| rate_hi | input | 1 | Rate select: 0 = 256 cycles per frame, 1 = 128 |
| dp_rst_n | output | 1 | Reset to the datapath, active low; 0 while unlocked |
| locked | output | 1 | 1 while the frame clock is in lock |

## Verification
The embedded assertions check on every cycle that a bad frame, a rate change or a timeout is followed by an unlocked state in the next cycle. They also check that lock only rises right after a correctly measured frame, and that every judged frame comes from a detected edge. The claims that depend on counts are shown only by the bench scenarios. These are: exactly four good frames are needed, off-by-one frames in both directions are rejected, the duty cycle is irrelevant, the timeout fires after 512 silent cycles but not after about 430, and the external reset clears lock at once.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  function automatic int unsigned frame_ratio(input logic hi, input int unsigned base);
    return hi ? (base / 2) : base;
  endfunction
endpackage

// File: rtl/fpm_edge_detect.sv
module fpm_edge_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/fpm_frame_counter.sv
module fpm_frame_counter #(
  parameter int TIMEOUT = 512,
  parameter int CW      = $clog2(TIMEOUT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise_i,
  input  logic          restart_i,
  input  logic [CW-1:0] ratio_i,
  output logic          frame_vld_o,
  output logic          frame_ok_o,
  output logic          timeout_o
);
  logic [CW-1:0] cnt_q;
  logic          have_ref_q;
  logic [CW-1:0] len;

  assign len = cnt_q + CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      have_ref_q  <= 1'b0;
      frame_vld_o <= 1'b0;
      frame_ok_o  <= 1'b0;
      timeout_o   <= 1'b0;
    end else begin
      frame_vld_o <= 1'b0;
      timeout_o   <= 1'b0;
      if (restart_i) begin
        cnt_q      <= '0;
        have_ref_q <= 1'b0;
      end else if (rise_i) begin
        frame_vld_o <= have_ref_q;
        frame_ok_o  <= (len == ratio_i);
        cnt_q       <= '0;
        have_ref_q  <= 1'b1;
      end else if (cnt_q == CW'(TIMEOUT - 1)) begin
        timeout_o  <= 1'b1;
        have_ref_q <= 1'b0;
      end else begin
        cnt_q <= len;
      end
    end
  end

  // R1: a judged frame always stems from a detected rising edge
  a_r1_frame_from_edge: assert property (@(posedge clk) disable iff (!rst_n)
    frame_vld_o |-> $past(rise_i));
  // R4: a timeout is never reported in the same cycle as a judged frame
  a_r4_timeout_excl: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> !frame_vld_o);
endmodule

// File: rtl/fpm_lock_tracker.sv
module fpm_lock_tracker #(
  parameter int GOOD = 4,
  parameter int GW   = $clog2(GOOD + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_vld_i,
  input  logic frame_ok_i,
  input  logic fault_i,
  output logic locked_o
);
  logic [GW-1:0] good_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good_q   <= '0;
      locked_o <= 1'b0;
    end else if (fault_i || (frame_vld_i && !frame_ok_i)) begin
      good_q   <= '0;
      locked_o <= 1'b0;
    end else if (frame_vld_i && good_q != GW'(GOOD)) begin
      good_q   <= good_q + GW'(1);
      locked_o <= (good_q == GW'(GOOD - 1));
    end
  end

  // R2: a mismatched frame drops lock
  a_r2_bad_frame_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_vld_i && !frame_ok_i) |=> !locked_o);
  // R4: a fault drops lock
  a_r4_fault_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i |=> !locked_o);
  // R5: lock only rises right after a good frame
  a_r5_rise_after_good: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_o) |-> $past(frame_vld_i && frame_ok_i && !fault_i));
endmodule

// File: rtl/frame_phase_monitor.sv
module frame_phase_monitor #(
  parameter int BASE_RATIO  = 256,
  parameter int TIMEOUT     = 512,
  parameter int GOOD_FRAMES = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic mclk,
  input  logic ext_rst_n,
  input  logic lrck,
  input  logic rate_hi,
  output logic dp_rst_n,
  output logic locked
);
  import fpm_pkg::*;
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] RATIO_LO = CW'(frame_ratio(1'b0, BASE_RATIO));
  localparam logic [CW-1:0] RATIO_HI = CW'(frame_ratio(1'b1, BASE_RATIO));

  logic          rise;
  logic [1:0]    rate_q;
  logic          rate_chg;
  logic [CW-1:0] ratio;
  logic          frame_vld, frame_ok, timeout;

  always_ff @(posedge mclk or negedge ext_rst_n) begin
    if (!ext_rst_n) rate_q <= '0;
    else            rate_q <= {rate_q[0], rate_hi};
  end
  assign rate_chg = rate_q[1] ^ rate_q[0];
  assign ratio    = rate_q[1] ? RATIO_HI : RATIO_LO;

  fpm_edge_detect #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(mclk), .rst_n(ext_rst_n), .async_i(lrck), .rise_o(rise));

  fpm_frame_counter #(.TIMEOUT(TIMEOUT)) u_count (
    .clk(mclk), .rst_n(ext_rst_n), .rise_i(rise), .restart_i(rate_chg),
    .ratio_i(ratio), .frame_vld_o(frame_vld), .frame_ok_o(frame_ok),
    .timeout_o(timeout));

  fpm_lock_tracker #(.GOOD(GOOD_FRAMES)) u_lock (
    .clk(mclk), .rst_n(ext_rst_n), .frame_vld_i(frame_vld),
    .frame_ok_i(frame_ok), .fault_i(timeout | rate_chg), .locked_o(locked));

  assign dp_rst_n = locked;

  // R3: a rate change drops lock
  a_r3_rate_change_unlocks: assert property (@(posedge mclk) disable iff (!ext_rst_n)
    rate_chg |=> !locked);
  // R3: no frame is judged right after a rate change
  a_r3_no_judge_after_change: assert property (@(posedge mclk) disable iff (!ext_rst_n)
    rate_chg |=> !frame_vld);
endmodule

// File: tb/tb_frame_phase_monitor.sv
module tb_frame_phase_monitor;
  logic mclk = 1'b0;
  logic ext_rst_n = 1'b0;
  logic lrck = 1'b0;
  logic rate_hi = 1'b0;
  logic dp_rst_n, locked;
  int   n_run = 0, n_fail = 0;

  always #2.5 mclk = ~mclk;

  frame_phase_monitor dut (
    .mclk(mclk), .ext_rst_n(ext_rst_n), .lrck(lrck), .rate_hi(rate_hi),
    .dp_rst_n(dp_rst_n), .locked(locked));

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic lock_chk(input string req, input logic exp);
    chk(req, locked, exp);
    chk({req, " R8"}, dp_rst_n, exp);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge mclk);
  endtask

  task automatic frames(input int n, input int len, input int hi);
    for (int i = 0; i < n; i++) begin
      lrck = 1'b1; cyc(hi);
      lrck = 1'b0; cyc(len - hi);
    end
  endtask

  task automatic t_reset;
    cyc(3);
    lock_chk("R7 reset state", 1'b0);
    ext_rst_n = 1'b1;
    cyc(3);
  endtask

  task automatic t_lock_normal;
    frames(4, 256, 128);
    lock_chk("R5 three good frames", 1'b0);
    frames(1, 256, 128);
    lock_chk("R1 lock at 256", 1'b1);
  endtask

  task automatic t_bad_len(input int len);
    frames(1, len, 100);
    frames(1, 256, 100);
    lock_chk("R2 wrong length unlocks", 1'b0);
    frames(3, 256, 100);
    lock_chk("R5 relock needs four", 1'b0);
    frames(1, 256, 100);
    lock_chk("R2 relock", 1'b1);
  endtask

  task automatic t_duty;
    frames(1, 256, 10);
    frames(1, 256, 250);
    frames(1, 256, 1);
    frames(1, 256, 255);
    lock_chk("R6 duty irrelevant", 1'b1);
  endtask

  task automatic t_rate_change;
    rate_hi = 1'b1;
    cyc(5);
    lock_chk("R3 rate change unlocks", 1'b0);
    frames(4, 128, 64);
    lock_chk("R3 reference plus three", 1'b0);
    frames(1, 128, 64);
    lock_chk("R1 lock at 128", 1'b1);
  endtask

  task automatic t_timeout;
    cyc(300);
    lock_chk("R4 no early timeout", 1'b1);
    cyc(150);
    lock_chk("R4 timeout unlocks", 1'b0);
    frames(4, 128, 30);
    lock_chk("R4 still unlocked", 1'b0);
    frames(1, 128, 30);
    lock_chk("R4 relock", 1'b1);
  endtask

  task automatic t_ext_reset;
    @(posedge mclk); #1 ext_rst_n = 1'b0;
    #1 lock_chk("R7 async reset", 1'b0);
    cyc(2);
    ext_rst_n = 1'b1;
    rate_hi = 1'b0;
    cyc(5);
    frames(4, 256, 128);
    lock_chk("R7 after reset needs frames", 1'b0);
    frames(1, 256, 128);
    lock_chk("R7 relock", 1'b1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_lock_normal();
        t_bad_len(257);
        t_bad_len(255);
        t_duty();
        t_rate_change();
        t_timeout();
        t_ext_reset();
      end
      begin
        cyc(150000);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule